// File: doc/BRIEF.md
# Stable Single-Bit Split Sorter

This block reorders a frame of N keys on one chosen bit position. Keys whose selected bit is 0 move to the front, and keys whose selected bit is 1 move to the back. Within each group the keys keep their input order. Destinations come from a single exclusive prefix count of the zero-bit flags. A zero-bit key goes to the number of zero-bit keys that come before it. A one-bit key goes to its own index minus that count, plus the total number of zero-bit keys in the frame. The keys are then scattered to those destinations in one cycle.

A frame is packed with key i at bits [i*W +: W] of the key buses. A pulse on `start` captures the frame. In single mode the block makes one pass on the bit chosen by `bitSel`. In full mode it makes W passes, starting at bit 0 and ending at bit W-1, which sorts the frame into ascending order. `done` pulses for one cycle when the result is ready. The result stays on `keysOut` until the next accepted start.

Top module: `bit_split_sorter`

## Requirements
- R1: After reset `done` is 0 and `keysOut` is all zeros.
- R2: In single mode, a `start` sampled while idle captures `keysIn` and performs one split on bit `bitSel`. `done` is 1 during exactly the second cycle after the start edge and 0 in the cycle after that.
- R3: A key whose selected bit is 0 lands at output slot f, where f is the number of zero-bit keys at lower input indices, so the zero-bit group stays in input order.
- R4: A key at index i whose selected bit is 1 lands at slot i - f + totalFalses, where totalFalses is the count of zero-bit keys in the frame, so the one-bit group follows every zero-bit key in input order.
- R5: With W=3, the inputs 100,111,010,110,011,101,001,000 (index 0 first) split on bit 0 give 100,010,110,000,111,011,101,001.
- R6: A frame whose selected bits are all 0, or all 1, leaves the output order identical to the input order.
- R7: In full mode (`fullSort`=1), W passes run on bits 0 to W-1 in that order and `bitSel` has no effect. `keysOut` is the ascending sort of the frame, and `done` is 1 during the (W+1)-th cycle after the start edge.
- R8: A `start` that arrives while a frame is in progress is ignored. Neither the result nor the timing of `done` changes.
- R9: Between operations `keysOut` holds its value whatever `keysIn`, `bitSel` and `fullSort` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| fullSort | input | 1 | 1: all W passes, LSB first; 0: one pass on bitSel |
| bitSel | input | BIT_W | Bit index for single mode; must be below W |
| keysIn | input | N*W | Input frame, key i at [i*W +: W] |
| keysOut | output | N*W | Result frame, same packing |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The assertions assume two things about the inputs. In single mode `bitSel` is below W. `start` is a synchronous level that the bench changes only away from the active edge. The stimulus drives every input on the falling edge and uses only bit indices 0 to W-1. It repeats `start` during a run only to exercise R8. Under those conditions the scatter must be a permutation, each pass must leave the frame partitioned on the bit it used, and `done` must follow the expected number of passes. Those are the properties the assertions rely on.

// File: rtl/split_sorter_pkg.sv
package split_sorter_pkg;
  typedef struct packed {
    logic load;
    logic split;
  } strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/split_sorter_ctrl.sv
module split_sorter_ctrl
  import split_sorter_pkg::*;
#(
  parameter int W = 3,
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             fullSort,
  input  logic [BIT_W-1:0] bitSel,
  output strobe_t          ctl,
  output logic [BIT_W-1:0] bitIdx,
  output logic             done
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  phase_t phase;
  logic   fullMode;
  logic   lastPass;

  always_comb begin
    ctl.load  = (phase == ST_IDLE) && start;
    ctl.split = (phase == ST_RUN);
    lastPass  = !fullMode || (bitIdx == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= ST_IDLE;
      bitIdx   <= '0;
      fullMode <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        phase    <= ST_RUN;
        fullMode <= fullSort;
        bitIdx   <= fullSort ? '0 : bitSel;
      end else if (ctl.split) begin
        if (lastPass) begin
          phase <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  // Independent pass counter, used only by the checks below
  logic [BIT_W:0] passCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) passCnt <= '0;
    else if (ctl.load) passCnt <= '0;
    else if (ctl.split) passCnt <= passCnt + 1'b1;
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_after_split_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(ctl.split));
  assert_pass_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (passCnt == (fullMode ? (BIT_W+1)'(W) : (BIT_W+1)'(1))));
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.split && start) |=> !$past(ctl.load));
endmodule

// File: rtl/split_sorter_dp.sv
module split_sorter_dp
  import split_sorter_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 3,
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          ctl,
  input  logic [BIT_W-1:0] bitIdx,
  input  logic [N*W-1:0]   keysIn,
  output logic [N*W-1:0]   keysOut
);
  logic [N*W-1:0] keyReg;
  logic [N*W-1:0] nextKeys;
  logic [W-1:0]   keyArr [N];
  logic           zeroFlag [N];
  logic [CNT_W-1:0] falsesBefore [N];
  logic [CNT_W-1:0] totalFalses;
  logic [IDX_W-1:0] dest [N];
  logic [N-1:0]     slotHit;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_unpack
      assign keyArr[gi] = keyReg[gi*W +: W];
    end
  endgenerate

  // Exclusive count of zero-bit keys, then destination per key
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      zeroFlag[i]     = ~keyArr[i][bitIdx];
      falsesBefore[i] = acc;
      acc             = acc + CNT_W'(zeroFlag[i]);
    end
    totalFalses = acc;
    for (int i = 0; i < N; i++) begin
      if (zeroFlag[i]) dest[i] = IDX_W'(falsesBefore[i]);
      else dest[i] = IDX_W'(CNT_W'(i) - falsesBefore[i] + totalFalses);
    end
  end

  // Scatter: each output slot picks the key addressed to it
  always_comb begin
    nextKeys = '0;
    slotHit  = '0;
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        if (dest[i] == IDX_W'(j)) begin
          nextKeys[j*W +: W] = keyArr[i];
          slotHit[j]         = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyReg <= '0;
    else if (ctl.load) keyReg <= keysIn;
    else if (ctl.split) keyReg <= nextKeys;
  end

  assign keysOut = keyReg;

  function automatic logic isPartitioned(input logic [N*W-1:0] frame,
                                         input logic [BIT_W-1:0] b);
    logic seenOne;
    logic ok;
    seenOne = 1'b0;
    ok      = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (frame[i*W + int'(b)]) seenOne = 1'b1;
      else if (seenOne) ok = 1'b0;
    end
    return ok;
  endfunction

  assert_scatter_perm_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.split |-> (&slotHit));
  assert_partition_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.split |=> isPartitioned(keyReg, $past(bitIdx)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load || ctl.split) |=> $stable(keyReg));
endmodule

// File: rtl/bit_split_sorter.sv
module bit_split_sorter
  import split_sorter_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 3,
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             fullSort,
  input  logic [BIT_W-1:0] bitSel,
  input  logic [N*W-1:0]   keysIn,
  output logic [N*W-1:0]   keysOut,
  output logic             done
);
  strobe_t          ctl;
  logic [BIT_W-1:0] bitIdx;

  split_sorter_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .fullSort(fullSort),
    .bitSel(bitSel), .ctl(ctl), .bitIdx(bitIdx), .done(done)
  );

  split_sorter_dp #(.N(N), .W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIdx(bitIdx),
    .keysIn(keysIn), .keysOut(keysOut)
  );
endmodule

// File: tb/sim_bit_split_sorter.sv
module sim_bit_split_sorter;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic fullSort = 1'b0;
  logic [1:0] bitSel = '0;
  logic [N*W-1:0] keysIn = '0;
  logic [N*W-1:0] keysOut;
  logic done;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  bit_split_sorter #(.N(N), .W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .fullSort(fullSort),
    .bitSel(bitSel), .keysIn(keysIn), .keysOut(keysOut), .done(done)
  );

  function automatic logic [N*W-1:0] pack8(input int a0, a1, a2, a3, a4, a5, a6, a7);
    int v [N];
    logic [N*W-1:0] r;
    v = '{a0, a1, a2, a3, a4, a5, a6, a7};
    r = '0;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(v[i]);
    return r;
  endfunction

  // Reference: zero-bit keys in order, then one-bit keys in order
  function automatic logic [N*W-1:0] refSplit(input logic [N*W-1:0] k, input int b);
    logic [N*W-1:0] r;
    int o;
    r = '0;
    o = 0;
    for (int i = 0; i < N; i++) if (!k[i*W + b]) begin r[o*W +: W] = k[i*W +: W]; o++; end
    for (int i = 0; i < N; i++) if (k[i*W + b]) begin r[o*W +: W] = k[i*W +: W]; o++; end
    return r;
  endfunction

  function automatic logic [N*W-1:0] refSort(input logic [N*W-1:0] k);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) a[i] = k[i*W +: W];
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0; j--)
        if (a[j] < a[j-1]) begin t = a[j]; a[j] = a[j-1]; a[j-1] = t; end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Issues one operation; optional extra start pulse during the run (R8)
  task automatic runOp(input logic [N*W-1:0] k, input int b, input bit full,
                       input logic [N*W-1:0] exp, input string tag, input bit poke);
    int lat;
    int want;
    want = full ? W + 1 : 2;
    @(negedge clk);
    keysIn = k; bitSel = 2'(b); fullSort = full; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      keysIn = ~k; fullSort = 1'b0; bitSel = 2'd1; start = 1'b1;
    end
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check(lat == want, {tag, " latency"}, N*W'(lat), N*W'(want));
    check(keysOut == exp, {tag, " data"}, keysOut, exp);
    @(negedge clk);
    check(done == 1'b0, {tag, " done pulse"}, N*W'(done), '0);
  endtask

  task automatic testReset();
    check(done == 1'b0, "R1 done", N*W'(done), '0);
    check(keysOut == '0, "R1 keysOut", keysOut, '0);
  endtask

  task automatic testExample();
    logic [N*W-1:0] k;
    k = pack8(4, 7, 2, 6, 3, 5, 1, 0);
    runOp(k, 0, 1'b0, pack8(4, 2, 6, 0, 7, 3, 5, 1), "R5 example", 1'b0);
  endtask

  task automatic testSingleBits();
    logic [N*W-1:0] k;
    k = pack8(5, 1, 6, 3, 0, 7, 2, 4);
    runOp(k, 1, 1'b0, refSplit(k, 1), "R2 R3 bit1", 1'b0);
    runOp(k, 2, 1'b0, refSplit(k, 2), "R3 R4 bit2", 1'b0);
    k = pack8(1, 0, 0, 0, 0, 0, 0, 0);
    runOp(k, 0, 1'b0, pack8(0, 0, 0, 0, 0, 0, 0, 1), "R4 single one at front", 1'b0);
    k = pack8(1, 1, 1, 1, 1, 1, 1, 0);
    runOp(k, 0, 1'b0, pack8(0, 1, 1, 1, 1, 1, 1, 1), "R3 single zero at back", 1'b0);
  endtask

  task automatic testUniform();
    logic [N*W-1:0] k;
    k = pack8(0, 2, 4, 6, 6, 4, 2, 0);
    runOp(k, 0, 1'b0, k, "R6 all zero bits", 1'b0);
    k = pack8(7, 5, 3, 1, 1, 3, 5, 7);
    runOp(k, 0, 1'b0, k, "R6 all one bits", 1'b0);
  endtask

  task automatic testFull();
    logic [N*W-1:0] k;
    k = pack8(4, 7, 2, 6, 3, 5, 1, 0);
    runOp(k, 2, 1'b1, refSort(k), "R7 full example", 1'b0);
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < N; i++) k[i*W +: W] = W'($urandom);
      runOp(k, n % 3, 1'b1, refSort(k), "R7 full random", 1'b0);
    end
  endtask

  task automatic testBusyStart();
    logic [N*W-1:0] k;
    k = pack8(3, 3, 1, 7, 0, 2, 6, 5);
    runOp(k, 0, 1'b1, refSort(k), "R8 start while busy", 1'b1);
  endtask

  task automatic testHold();
    logic [N*W-1:0] held;
    held = keysOut;
    @(negedge clk);
    keysIn = ~held; bitSel = 2'd2; fullSort = 1'b1;
    repeat (5) @(negedge clk);
    check(keysOut == held, "R9 hold", keysOut, held);
    check(done == 1'b0, "R9 no done", N*W'(done), '0);
  endtask

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testExample();
    testSingleBits();
    testUniform();
    testFull();
    testBusyStart();
    testHold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule